// File: doc/BRIEF.md
# Predicated Contiguous Vector Store Sequencer

This block turns one vector store command into a run of 64-bit memory write beats. A command carries a whole vector register value, a byte-granular predicate mask, a 64-bit base address, a 64-bit scalar index, and a flag that marks the base as the stack pointer. The block computes a start address by scaling the index by the 8-byte element size and adding it to the base. It then visits every element from lowest to highest. An element whose predicate bit is set becomes one beat on a valid/ready write port. An element whose bit is clear is passed over without a beat, but the address still moves on past it.

Every beat carries a non-temporal hint and a contiguous/predicated attribute, so the memory side can treat the stream as streaming data. When the base is the stack pointer, a 16-byte alignment check decides whether the store runs at all. A failed check reports a fault together with the completion pulse, and no beat is issued. The time a command takes depends only on the predicate, the command fields and the back-pressure from the port. It never depends on the data being stored.

Top module: `vec_store_seq`

## Requirements
- R1: The address of element 0 is cmd_base + cmd_index × 8, computed modulo 2^64.
- R2: Element e is written to start + 8·e. The address advances by 8 after every element, whether or not that element was written.
- R3: Element e is active only when predicate bit 8·e is set. The other seven bits of its byte group are ignored. An inactive element produces no beat.
- R4: The beat for element e carries cmd_vec[64·e+63 : 64·e] as data and 8'hFF as byte strobe.
- R5: Every beat has wr_nontemp = 1 and wr_contig_pred = 1.
- R6: Once wr_valid is high with wr_ready low, the beat (valid, address, data) is held unchanged on the next cycle.
- R7: When cmd_base_is_sp = 1, cmd_base[3:0] ≠ 0, and at least one element is active, the command faults. No beat is issued, and done and fault are both high in the cycle after acceptance.
- R8: When no element is active, the stack pointer check runs only if cfg_sp_chk_none_active = 1. With it at 0, a misaligned stack pointer base completes without a fault.
- R9: done is a one-cycle pulse. For a command that does not fault, it is high exactly NE + S + 1 cycles after the acceptance edge, where NE = VL/64 and S is the number of cycles with wr_valid high and wr_ready low. Outside a fault, fault stays 0.
- R10: cmd_ready is high exactly when the block is idle. A command is taken only on a cycle with cmd_valid and cmd_ready both high.
- R11: After reset, cmd_ready = 1 and wr_valid, done and fault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command is taken |
| cmd_vec | input | VL | Vector value, element 0 in bits [63:0] |
| cmd_pred | input | VL/8 | Predicate, one bit per vector byte |
| cmd_base | input | 64 | Base address |
| cmd_index | input | 64 | Scalar element index |
| cmd_base_is_sp | input | 1 | Base comes from the stack pointer |
| cfg_sp_chk_none_active | input | 1 | Run the stack pointer check when no element is active |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory port takes the beat |
| wr_addr | output | 64 | Beat byte address |
| wr_data | output | 64 | Beat data |
| wr_strb | output | 8 | Byte strobe |
| wr_nontemp | output | 1 | Non-temporal hint |
| wr_contig_pred | output | 1 | Contiguous, predicated attribute |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, valid with done |

## Verification
The assertions rely on two assumptions about the inputs. cmd_valid is sampled only while the block is idle, and wr_ready may toggle freely but is never assumed to rise. The bench keeps within these limits by raising cmd_valid for a single cycle and only after the previous done pulse. It drives wr_ready either tied high or from a random pattern, so stalls of many lengths occur, including stalls on the last element. The stimulus covers all-active and sparse predicates, predicates with stray non-governing bits set, an address that wraps past 2^64, and each combination of stack pointer flag, base alignment, active count and check configuration.

// File: rtl/vss_pkg.sv
package vss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vss_state_e;

endpackage

// File: rtl/vss_addr_gen.sv
module vss_addr_gen #(
    parameter int AW  = 64,
    parameter int ESH = 3
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    output logic [AW-1:0] start_o
);

    logic [AW-1:0] scaled;

    // index scaled by element bytes, wrap-around sum
    always_comb begin
        scaled  = index_i << ESH;
        start_o = base_i + scaled;
    end

endmodule

// File: rtl/vss_pred_gather.sv
module vss_pred_gather #(
    parameter int NE = 4,
    parameter int EB = 8
) (
    input  logic [NE*EB-1:0] pred_i,
    output logic [NE-1:0]    act_o,
    output logic             any_o
);

    // only the lowest bit of each element's byte group governs it
    for (genvar g = 0; g < NE; g++) begin : g_gov
        assign act_o[g] = pred_i[g*EB];
    end

    assign any_o = |act_o;

endmodule

// File: rtl/vss_align_chk.sv
module vss_align_chk #(
    parameter int ALB = 4
) (
    input  logic [ALB-1:0] base_lo_i,
    input  logic           is_sp_i,
    input  logic           any_active_i,
    input  logic           chk_none_i,
    output logic           fault_o
);

    logic run_chk;
    logic misalign;

    always_comb begin
        run_chk  = is_sp_i && (any_active_i || chk_none_i);
        misalign = (base_lo_i != '0);
        fault_o  = run_chk && misalign;
    end

endmodule

// File: rtl/vss_elem_sel.sv
module vss_elem_sel #(
    parameter int EW = 64,
    parameter int NE = 4,
    parameter int IW = 2
) (
    input  logic [NE*EW-1:0] vec_i,
    input  logic [NE-1:0]    act_i,
    input  logic [IW-1:0]    idx_i,
    output logic [EW-1:0]    data_o,
    output logic             active_o
);

    logic [EW-1:0] lane [NE];

    for (genvar g = 0; g < NE; g++) begin : g_lane
        assign lane[g] = vec_i[g*EW +: EW];
    end

    assign data_o   = lane[idx_i];
    assign active_o = act_i[idx_i];

endmodule

// File: rtl/vec_store_seq.sv
module vec_store_seq
    import vss_pkg::*;
#(
    parameter int VL    = 256,
    parameter int AW    = 64,
    parameter int ALIGN = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [VL-1:0]   cmd_vec,
    input  logic [VL/8-1:0] cmd_pred,
    input  logic [AW-1:0]   cmd_base,
    input  logic [AW-1:0]   cmd_index,
    input  logic            cmd_base_is_sp,
    input  logic            cfg_sp_chk_none_active,
    output logic            wr_valid,
    input  logic            wr_ready,
    output logic [AW-1:0]   wr_addr,
    output logic [63:0]     wr_data,
    output logic [7:0]      wr_strb,
    output logic            wr_nontemp,
    output logic            wr_contig_pred,
    output logic            done,
    output logic            fault
);

    localparam int EW  = 64;
    localparam int EB  = EW / 8;
    localparam int ESH = $clog2(EB);
    localparam int NE  = VL / EW;
    localparam int IW  = (NE > 1) ? $clog2(NE) : 1;
    localparam int ALB = $clog2(ALIGN);
    localparam logic [IW-1:0] LAST = IW'(NE - 1);

    typedef struct packed {
        vss_state_e      state;
        logic [IW-1:0]   idx;
        logic [AW-1:0]   addr;
        logic [VL-1:0]   vec;
        logic [NE-1:0]   act;
        logic            flt;
    } seq_t;

    seq_t q, d;

    logic [AW-1:0] start_addr;
    logic [NE-1:0] cmd_act;
    logic          cmd_any;
    logic          cmd_fault;
    logic [EW-1:0] cur_data;
    logic          cur_active;
    logic          elem_adv;

    vss_addr_gen #(.AW(AW), .ESH(ESH)) u_addr (
        .base_i  (cmd_base),
        .index_i (cmd_index),
        .start_o (start_addr)
    );

    vss_pred_gather #(.NE(NE), .EB(EB)) u_pred (
        .pred_i (cmd_pred),
        .act_o  (cmd_act),
        .any_o  (cmd_any)
    );

    vss_align_chk #(.ALB(ALB)) u_align (
        .base_lo_i    (cmd_base[ALB-1:0]),
        .is_sp_i      (cmd_base_is_sp),
        .any_active_i (cmd_any),
        .chk_none_i   (cfg_sp_chk_none_active),
        .fault_o      (cmd_fault)
    );

    vss_elem_sel #(.EW(EW), .NE(NE), .IW(IW)) u_sel (
        .vec_i    (q.vec),
        .act_i    (q.act),
        .idx_i    (q.idx),
        .data_o   (cur_data),
        .active_o (cur_active)
    );

    // an element retires when skipped or when its beat is taken
    assign elem_adv = (q.state == ST_RUN) && (!cur_active || wr_ready);

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    d.vec   = cmd_vec;
                    d.act   = cmd_act;
                    d.addr  = start_addr;
                    d.idx   = '0;
                    d.flt   = cmd_fault;
                    d.state = cmd_fault ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (elem_adv) begin
                    d.addr = q.addr + AW'(EB);
                    d.idx  = q.idx + 1'b1;
                    if (q.idx == LAST) begin
                        d.state = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.idx   <= '0;
            q.addr  <= '0;
            q.vec   <= '0;
            q.act   <= '0;
            q.flt   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready      = (q.state == ST_IDLE);
    assign wr_valid       = (q.state == ST_RUN) && cur_active;
    assign wr_addr        = q.addr;
    assign wr_data        = cur_data;
    assign wr_strb        = 8'hFF;
    assign wr_nontemp     = 1'b1;
    assign wr_contig_pred = 1'b1;
    assign done           = (q.state == ST_DONE);
    assign fault          = (q.state == ST_DONE) && q.flt;

    // R6: a stalled beat is held
    a_r6_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: address steps by one element whenever a non-final element retires
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_adv && (q.idx != LAST)) |=> (wr_addr == $past(wr_addr) + AW'(EB)));

    // R10: no command is taken while completing
    a_r10_busy_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready);

    // R7: a fault only appears with completion and never with a beat
    a_r7_fault_silent: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !wr_valid));

    // R7: a faulting command completes in the next cycle
    a_r7_fault_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_fault) |=> (done && fault));

endmodule

// File: tb/vec_store_seq_tb.sv
`timescale 1ns/1ps
module vec_store_seq_tb;

    localparam int VL = 256;
    localparam int NE = VL / 64;
    localparam int PW = VL / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [VL-1:0]   cmd_vec = '0;
    logic [PW-1:0]   cmd_pred = '0;
    logic [63:0]     cmd_base = '0;
    logic [63:0]     cmd_index = '0;
    logic            cmd_base_is_sp = 1'b0;
    logic            cfg_sp_chk_none_active = 1'b0;
    logic            wr_valid;
    logic            wr_ready = 1'b1;
    logic [63:0]     wr_addr;
    logic [63:0]     wr_data;
    logic [7:0]      wr_strb;
    logic            wr_nontemp;
    logic            wr_contig_pred;
    logic            done;
    logic            fault;

    always #2.5 clk = ~clk;

    vec_store_seq #(.VL(VL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_vec(cmd_vec), .cmd_pred(cmd_pred),
        .cmd_base(cmd_base), .cmd_index(cmd_index),
        .cmd_base_is_sp(cmd_base_is_sp),
        .cfg_sp_chk_none_active(cfg_sp_chk_none_active),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .wr_nontemp(wr_nontemp), .wr_contig_pred(wr_contig_pred),
        .done(done), .fault(fault)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    bit finished = 1'b0;

    // reference model state
    logic [63:0] exp_addr_q [$];
    logic [63:0] exp_data_q [$];
    bit          exp_first_q [$];
    bit          busy = 1'b0;
    int          cnt = 0;
    int          stalls = 0;
    bit          exp_fault = 1'b0;
    string       fault_tag = "R7";
    bit          prev_stall = 1'b0;
    int          ready_mode = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // ready pattern driven away from the sampling edge
    always begin
        @(posedge clk);
        #1;
        if (ready_mode == 0) wr_ready = 1'b1;
        else wr_ready = ($urandom_range(0, 2) != 0);
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) cnt++;
            chk(cmd_ready == !busy, "R10 cmd_ready", 64'(cmd_ready), 64'(!busy));
            if (prev_stall) chk(wr_valid, "R6 held valid", 64'(wr_valid), 64'd1);
            prev_stall = 1'b0;
            if (wr_valid) begin
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected beat", wr_addr, 64'd0);
                end else begin
                    chk(wr_addr == exp_addr_q[0], exp_first_q[0] ? "R1 addr" : "R2 addr",
                        wr_addr, exp_addr_q[0]);
                    chk(wr_data == exp_data_q[0], "R4 data", wr_data, exp_data_q[0]);
                    chk(wr_strb == 8'hFF, "R4 strobe", 64'(wr_strb), 64'hFF);
                    chk(wr_nontemp && wr_contig_pred, "R5 hints",
                        64'({wr_nontemp, wr_contig_pred}), 64'h3);
                    if (wr_ready) begin
                        void'(exp_addr_q.pop_front());
                        void'(exp_data_q.pop_front());
                        void'(exp_first_q.pop_front());
                    end else begin
                        stalls++;
                        prev_stall = 1'b1;
                    end
                end
            end
            if (done) begin
                if (!busy) begin
                    chk(1'b0, "R9 stray done", 64'd1, 64'd0);
                end else begin
                    chk(cnt == (exp_fault ? 1 : NE + stalls + 1), "R9 latency",
                        64'(cnt), 64'(exp_fault ? 1 : NE + stalls + 1));
                    chk(fault == exp_fault, fault_tag, 64'(fault), 64'(exp_fault));
                    chk(exp_addr_q.size() == 0, "R3 missing beats",
                        64'(exp_addr_q.size()), 64'd0);
                    busy = 1'b0;
                    n_done++;
                end
            end else begin
                chk(!fault, "R9 fault without done", 64'(fault), 64'd0);
            end
            if (cmd_valid && cmd_ready) begin
                busy = 1'b1;
                cnt = 0;
                stalls = 0;
            end
        end
    end

    task automatic send(input logic [VL-1:0] vec, input logic [PW-1:0] pred,
                        input logic [63:0] base, input logic [63:0] index,
                        input bit sp, input bit chk_none, input string tag);
        logic [63:0] start;
        bit any;
        int n0;
        while (busy) @(posedge clk);
        @(posedge clk);
        #1;
        start = base + (index * 64'd8);
        any = 1'b0;
        for (int e = 0; e < NE; e++) if (pred[8*e]) any = 1'b1;
        exp_fault = sp && (any || chk_none) && (base[3:0] != 4'd0);
        fault_tag = tag;
        if (!exp_fault) begin
            for (int e = 0; e < NE; e++) begin
                if (pred[8*e]) begin
                    exp_addr_q.push_back(start + 64'(8 * e));
                    exp_data_q.push_back(vec[64*e +: 64]);
                    exp_first_q.push_back(e == 0);
                end
            end
        end
        cmd_vec = vec;
        cmd_pred = pred;
        cmd_base = base;
        cmd_index = index;
        cmd_base_is_sp = sp;
        cfg_sp_chk_none_active = chk_none;
        cmd_valid = 1'b1;
        n0 = n_done;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        while (n_done == n0) @(negedge clk);
    endtask

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] v;
        for (int w = 0; w < VL / 32; w++) v[32*w +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(cmd_ready && !wr_valid && !done && !fault, "R11 reset outputs",
            64'({cmd_ready, wr_valid, done, fault}), 64'h8);

        // R1/R2/R4: all active
        send(rand_vec(), 32'h0101_0101, 64'h1000, 64'd3, 1'b0, 1'b0, "R7");
        // R3: sparse, stray non-governing bits set
        send(rand_vec(), 32'h01FE_01FE, 64'h2008, 64'd1, 1'b0, 1'b0, "R7");
        // R1: wrap past 2^64
        send(rand_vec(), 32'h0101_0101, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 1'b0, 1'b0, "R7");
        // R8: no active, check off, misaligned sp
        send(rand_vec(), 32'hFEFE_FEFE, 64'h3004, 64'd0, 1'b1, 1'b0, "R8");
        // R8: no active, check on, misaligned sp
        send(rand_vec(), 32'h0, 64'h3004, 64'd0, 1'b1, 1'b1, "R8");
        // R7: active, aligned sp
        send(rand_vec(), 32'h0100_0001, 64'h4010, 64'd2, 1'b1, 1'b0, "R7");
        // R7: active, misaligned sp
        send(rand_vec(), 32'h0101_0101, 64'h4018, 64'd2, 1'b1, 1'b0, "R7");
        // R7: misaligned but not sp
        send(rand_vec(), 32'h0001_0100, 64'h4018, 64'd2, 1'b0, 1'b1, "R7");

        // R6/R9: back-pressure
        ready_mode = 1;
        send(rand_vec(), 32'h0101_0101, 64'h5000, 64'd7, 1'b0, 1'b0, "R7");
        send(rand_vec(), 32'h0100_0100, 64'h5000, 64'd9, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 40; i++) begin
            send(rand_vec(), PW'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
                 1'($urandom), 1'($urandom), "R7");
        end
        ready_mode = 0;
        repeat (3) @(posedge clk);
        summary();
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", n_done, 50);
        summary();
    end

endmodule